// File: doc/BRIEF.md
# I2C Register Target

This block is a serial-bus target that lets an external controller read and write a bank of 8-bit registers over the two open-drain I2C lines. It samples SCL and SDA on the system clock and recognises START, repeated START and STOP. It compares the address byte against a 7-bit identity that is built from fixed upper bits and a few pin-programmed lower bits, so several copies of the block can share one bus. On a match it acknowledges the address.

In write direction, the first byte after the address becomes the register pointer. Each later byte is written into the bank at that pointer. To read, the controller writes the pointer, issues a repeated START and then sends the address with the read bit set. The block then returns bytes starting at the stored pointer.

The block keeps one control register of its own. Bit 0 of that register enables pointer auto-increment, and it is set out of reset. All other addresses go to the external bank through a single-cycle write strobe and a combinational read port.

Top module: `i2c_reg_target`

## Requirements
- R1: After reset the block leaves SDA released (sda_pull_o = 0) and raises no bank write strobe.
- R2: The address byte carries the 7-bit identity {BASE_ADDR[6:PIN_BITS], addr_pins_i} MSB first, followed by a direction bit (1 = controller reads, 0 = controller writes). The block acknowledges only a full 7-bit match. On a mismatch it stays silent and ignores the bus until the next START.
- R3: In a write transfer, the byte after the address is the sub-address. Its bits 6:0 load the register pointer and its bit 7 is ignored.
- R4: Every later write byte is acknowledged and produces exactly one single-cycle reg_wr_o pulse, with reg_addr_o equal to the pointer and reg_wdata_o equal to the byte.
- R5: After a repeated START and a matching address with the read bit set, the block returns bytes MSB first, starting at the stored pointer. Each controller ACK leads to the next byte.
- R6: The control register lives at CTRL_ADDR (default 0x30) inside the block, and writing it raises no bank strobe. While its bit 0 is 0, the pointer does not move, so repeated transfers reach the same register.
- R7: While control bit 0 is 1, the pointer advances by one after each data byte read or written, and wraps from 0x7F to 0x00.
- R8: A controller NACK after a read byte stops all SDA driving until the next START or STOP.
- R9: When the block acknowledges, it holds SDA low for the whole high phase of the ninth clock and releases it after the following SCL fall.
- R10: A STOP returns the block to idle with SDA released. Bytes clocked afterwards without a START are neither acknowledged nor written.
- R11: The control register resets to 0x01 and reads back at CTRL_ADDR like any other register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8 times the SCL rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_pull_o | output | 1 | 1 pulls SDA low, 0 releases it |
| addr_pins_i | input | PIN_BITS | Programmable low bits of the target identity |
| reg_addr_o | output | 7 | Register pointer, used for both bank read and bank write |
| reg_wr_o | output | 1 | Single-cycle bank write strobe |
| reg_wdata_o | output | 8 | Byte to be written into the bank |
| reg_rdata_i | input | 8 | Bank contents at reg_addr_o |

## Verification
The hardest case to reach from the ports is a pointer that crosses 0x7F in the middle of a burst. The same sequence must also show that a disabled increment really freezes the pointer. Both depend on state that builds up across several transfers. To get there, the stimulus first sets the pointer near the top of the range with a sub-address, then writes a three-byte burst that crosses the wrap, and reads the same span back after a repeated START. Next it clears the control bit through the bus and sends a burst to a single address. The bench model tracks the pointer, the control byte and a copy of the bank. It checks every write strobe as it occurs and every returned byte.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

    localparam int PTR_W = 7;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_SUB,
        ST_SUB_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RDATA_ACK
    } tgt_state_e;

    typedef struct packed {
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
        logic sda;
    } bus_evt_t;

endpackage

// File: rtl/i2c_bus_cond.sv
module i2c_bus_cond
    import i2c_tgt_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     scl_i,
    input  logic     sda_i,
    output bus_evt_t evt_o
);

    localparam int N = SYNC_STAGES;

    typedef struct packed {
        logic [N:0] scl;
        logic [N:0] sda;
    } cond_t;

    cond_t q, d;

    logic scl_cur, scl_prev, sda_cur, sda_prev;

    always_comb begin
        d     = q;
        d.scl = {q.scl[N-1:0], scl_i};
        d.sda = {q.sda[N-1:0], sda_i};
    end

    assign scl_cur  = q.scl[N-1];
    assign scl_prev = q.scl[N];
    assign sda_cur  = q.sda[N-1];
    assign sda_prev = q.sda[N];

    assign evt_o.scl_rise = scl_cur & ~scl_prev;
    assign evt_o.scl_fall = ~scl_cur & scl_prev;
    assign evt_o.start    = scl_cur & scl_prev & sda_prev & ~sda_cur;
    assign evt_o.stop     = scl_cur & scl_prev & ~sda_prev & sda_cur;
    assign evt_o.sda      = sda_cur;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.scl <= '1;
            q.sda <= '1;
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/i2c_tgt_fsm.sv
module i2c_tgt_fsm
    import i2c_tgt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  bus_evt_t         evt_i,
    input  logic [6:0]       dev_addr_i,
    input  logic             autoinc_i,
    input  logic [7:0]       rdata_i,
    output logic             sda_pull_o,
    output logic [PTR_W-1:0] ptr_o,
    output logic             wr_o,
    output logic [7:0]       wdata_o
);

    typedef struct packed {
        tgt_state_e       state;
        logic [2:0]       bitcnt;
        logic [7:0]       shift;
        logic [PTR_W-1:0] ptr;
        logic             rw;
        logic             pend;
        logic             mack;
        logic             wr;
        logic [7:0]       wdata;
        logic             sda_pull;
    } fsm_t;

    localparam logic [PTR_W-1:0] PTR_ONE = {{(PTR_W-1){1'b0}}, 1'b1};

    fsm_t q, d;
    logic [7:0] nb;
    logic       step;
    logic       load;

    always_comb begin
        d    = q;
        d.wr = 1'b0;
        step = 1'b0;
        load = 1'b0;
        nb   = {q.shift[6:0], evt_i.sda};
        if (evt_i.stop) begin
            d.state    = ST_IDLE;
            d.sda_pull = 1'b0;
            d.pend     = 1'b0;
        end else if (evt_i.start) begin
            d.state    = ST_ADDR;
            d.bitcnt   = 3'd0;
            d.sda_pull = 1'b0;
            d.pend     = 1'b0;
        end else begin
            unique case (q.state)
                ST_ADDR, ST_SUB, ST_WDATA: begin
                    if (evt_i.scl_rise && !q.pend) begin
                        d.shift  = nb;
                        d.bitcnt = 3'(q.bitcnt + 3'd1);
                        if (q.bitcnt == 3'd7) begin
                            if (q.state == ST_ADDR) begin
                                if (nb[7:1] == dev_addr_i) begin
                                    d.rw   = nb[0];
                                    d.pend = 1'b1;
                                end else begin
                                    d.state = ST_IDLE;
                                end
                            end else if (q.state == ST_SUB) begin
                                d.ptr  = nb[PTR_W-1:0];
                                d.pend = 1'b1;
                            end else begin
                                d.wr    = 1'b1;
                                d.wdata = nb;
                                d.pend  = 1'b1;
                            end
                        end
                    end else if (evt_i.scl_fall && q.pend) begin
                        d.pend     = 1'b0;
                        d.sda_pull = 1'b1;
                        if (q.state == ST_ADDR) begin
                            d.state = ST_ADDR_ACK;
                        end else if (q.state == ST_SUB) begin
                            d.state = ST_SUB_ACK;
                        end else begin
                            d.state = ST_WDATA_ACK;
                            step    = 1'b1;
                        end
                    end
                end
                ST_ADDR_ACK: begin
                    if (evt_i.scl_fall) begin
                        d.sda_pull = 1'b0;
                        d.bitcnt   = 3'd0;
                        if (q.rw) begin
                            load = 1'b1;
                        end else begin
                            d.state = ST_SUB;
                        end
                    end
                end
                ST_SUB_ACK, ST_WDATA_ACK: begin
                    if (evt_i.scl_fall) begin
                        d.sda_pull = 1'b0;
                        d.bitcnt   = 3'd0;
                        d.state    = ST_WDATA;
                    end
                end
                ST_RDATA: begin
                    if (evt_i.scl_fall) begin
                        if (q.bitcnt == 3'd7) begin
                            d.sda_pull = 1'b0;
                            d.state    = ST_RDATA_ACK;
                        end else begin
                            d.shift    = {q.shift[6:0], 1'b0};
                            d.sda_pull = ~q.shift[6];
                            d.bitcnt   = 3'(q.bitcnt + 3'd1);
                        end
                    end
                end
                ST_RDATA_ACK: begin
                    if (evt_i.scl_rise) begin
                        d.mack = ~evt_i.sda;
                    end else if (evt_i.scl_fall) begin
                        if (q.mack) begin
                            load = 1'b1;
                        end else begin
                            d.state = ST_IDLE;
                        end
                    end
                end
                default: begin
                end
            endcase
            if (load) begin
                d.shift    = rdata_i;
                d.sda_pull = ~rdata_i[7];
                d.bitcnt   = 3'd0;
                d.state    = ST_RDATA;
                step       = 1'b1;
            end
        end
        if (step && autoinc_i) begin
            d.ptr = q.ptr + PTR_ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q          <= '0;
            q.state    <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign sda_pull_o = q.sda_pull;
    assign ptr_o      = q.ptr;
    assign wr_o       = q.wr;
    assign wdata_o    = q.wdata;

    // R10: a STOP always leaves the block idle and off the bus
    assert_stop_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        evt_i.stop |=> (q.state == ST_IDLE && !q.sda_pull));

    // R2: a START always restarts address reception from bit zero
    assert_start_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_i.start && !evt_i.stop) |=> (q.state == ST_ADDR && q.bitcnt == 3'd0));

    // R4: bank write strobe never lasts more than one cycle
    assert_wr_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        q.wr |=> !q.wr);

    // R7: pointer rolls over from the top address to zero
    assert_ptr_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (step && autoinc_i && q.ptr == '1) |=> (q.ptr == '0));

    // R9: acknowledge of a data byte holds SDA low until SCL falls
    assert_ack_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_WDATA_ACK && !evt_i.scl_fall && !evt_i.start && !evt_i.stop)
        |=> q.sda_pull);

endmodule

// File: rtl/i2c_reg_target.sv
module i2c_reg_target
    import i2c_tgt_pkg::*;
#(
    parameter int         PIN_BITS    = 2,
    parameter logic [6:0] BASE_ADDR   = 7'h50,
    parameter logic [6:0] CTRL_ADDR   = 7'h30,
    parameter int         AUTOINC_BIT = 0,
    parameter int         SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                scl_i,
    input  logic                sda_i,
    output logic                sda_pull_o,
    input  logic [PIN_BITS-1:0] addr_pins_i,
    output logic [6:0]          reg_addr_o,
    output logic                reg_wr_o,
    output logic [7:0]          reg_wdata_o,
    input  logic [7:0]          reg_rdata_i
);

    localparam logic [7:0] CTRL_RST = 8'h01 << AUTOINC_BIT;

    bus_evt_t         evt;
    logic [6:0]       dev_addr;
    logic [PTR_W-1:0] ptr;
    logic             fsm_wr;
    logic [7:0]       fsm_wdata;
    logic [7:0]       rd_mux;
    logic             ctrl_hit;
    logic [7:0]       ctrl_d, ctrl_q;

    assign dev_addr = {BASE_ADDR[6:PIN_BITS], addr_pins_i};
    assign ctrl_hit = (ptr == CTRL_ADDR);
    assign rd_mux   = ctrl_hit ? ctrl_q : reg_rdata_i;

    i2c_bus_cond #(.SYNC_STAGES(SYNC_STAGES)) i_cond (
        .clk   (clk),
        .rst_n (rst_n),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .evt_o (evt)
    );

    i2c_tgt_fsm i_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt_i      (evt),
        .dev_addr_i (dev_addr),
        .autoinc_i  (ctrl_q[AUTOINC_BIT]),
        .rdata_i    (rd_mux),
        .sda_pull_o (sda_pull_o),
        .ptr_o      (ptr),
        .wr_o       (fsm_wr),
        .wdata_o    (fsm_wdata)
    );

    always_comb begin
        ctrl_d = ctrl_q;
        if (fsm_wr && ctrl_hit) begin
            ctrl_d = fsm_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= CTRL_RST;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign reg_addr_o  = ptr;
    assign reg_wr_o    = fsm_wr && !ctrl_hit;
    assign reg_wdata_o = fsm_wdata;

    // R6: control byte changes only through a bus write at its own address
    assert_ctrl_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(fsm_wr && ctrl_hit) |=> $stable(ctrl_q));

endmodule

// File: tb/test_i2c_reg_target.sv
module test_i2c_reg_target;

    localparam int CLK_PERIOD = 10;
    localparam int Q          = 6;
    localparam logic [6:0] DEV  = 7'h53;
    localparam logic [6:0] CTRL = 7'h30;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       m_scl = 1'b1;
    logic       m_sda_low = 1'b0;
    logic       sda;
    logic       sda_pull_o;
    logic [6:0] reg_addr_o;
    logic       reg_wr_o;
    logic [7:0] reg_wdata_o;
    logic [7:0] reg_rdata_i;
    logic [7:0] bank [128];

    int  n_chk = 0;
    int  n_fail = 0;
    bit  done = 1'b0;

    logic [7:0]  m_mem [128];
    logic [7:0]  m_ctrl;
    logic [6:0]  m_ptr;
    logic [14:0] exp_wr_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    assign sda = ~(m_sda_low | sda_pull_o);

    i2c_reg_target i_i2c_reg_target (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_i       (m_scl),
        .sda_i       (sda),
        .sda_pull_o  (sda_pull_o),
        .addr_pins_i (2'b11),
        .reg_addr_o  (reg_addr_o),
        .reg_wr_o    (reg_wr_o),
        .reg_wdata_o (reg_wdata_o),
        .reg_rdata_i (reg_rdata_i)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < 128; i++) bank[i] <= 8'(i) ^ 8'h5A;
        end else if (reg_wr_o) begin
            bank[reg_addr_o] <= reg_wdata_o;
        end
    end
    assign reg_rdata_i = bank[reg_addr_o];

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // R4: every bank strobe is compared against the model queue
    always @(negedge clk) begin
        if (rst_n && reg_wr_o) begin
            if (exp_wr_q.size() == 0) begin
                check(1'b0, "R4 unexpected write", {reg_addr_o, reg_wdata_o}, 0);
            end else begin
                logic [14:0] e;
                e = exp_wr_q.pop_front();
                check({reg_addr_o, reg_wdata_o} == e, "R4 write addr/data",
                      {reg_addr_o, reg_wdata_o}, e);
            end
        end
    end

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_bit(input bit b);
        wt(Q);
        m_sda_low = ~b;
        wt(Q);
        m_scl = 1'b1;
        wt(2*Q);
        m_scl = 1'b0;
    endtask

    task automatic bus_start();
        m_sda_low = 1'b1;
        wt(2*Q);
        m_scl = 1'b0;
    endtask

    task automatic bus_rstart();
        m_sda_low = 1'b0;
        wt(Q);
        m_scl = 1'b1;
        wt(2*Q);
        m_sda_low = 1'b1;
        wt(2*Q);
        m_scl = 1'b0;
    endtask

    task automatic bus_stop();
        m_sda_low = 1'b1;
        wt(Q);
        m_scl = 1'b1;
        wt(2*Q);
        m_sda_low = 1'b0;
        wt(2*Q);
    endtask

    task automatic send_byte(input logic [7:0] b, input bit exp_ack, input string req);
        logic s1, s2;
        for (int i = 7; i >= 0; i--) write_bit(b[i]);
        m_sda_low = 1'b0;
        wt(2*Q);
        m_scl = 1'b1;
        wt(1);
        s1 = sda;
        wt(2*Q - 2);
        s2 = sda;
        wt(1);
        m_scl = 1'b0;
        if (exp_ack) check(s1 == 1'b0 && s2 == 1'b0, {req, " R9 ack held"}, {s1, s2}, 0);
        else         check(s1 == 1'b1 && s2 == 1'b1, {req, " no ack"}, {s1, s2}, 3);
    endtask

    task automatic recv_byte(output logic [7:0] b, input bit ack);
        for (int i = 7; i >= 0; i--) begin
            m_sda_low = 1'b0;
            wt(2*Q);
            m_scl = 1'b1;
            wt(Q);
            b[i] = sda;
            wt(Q);
            m_scl = 1'b0;
        end
        write_bit(~ack);
    endtask

    task automatic model_write(input logic [7:0] v);
        if (m_ptr == CTRL) begin
            m_ctrl = v;
        end else begin
            exp_wr_q.push_back({m_ptr, v});
            m_mem[m_ptr] = v;
        end
        if (m_ctrl[0]) m_ptr = m_ptr + 7'd1;
    endtask

    task automatic wr_txn(input logic [6:0] dev, input bit match, input logic [7:0] sub,
                          input logic [7:0] data[$]);
        bus_start();
        send_byte({dev, 1'b0}, match, "R2");
        if (match) begin
            send_byte(sub, 1'b1, "R3");
            m_ptr = sub[6:0];
            foreach (data[i]) begin
                model_write(data[i]);
                send_byte(data[i], 1'b1, "R4");
            end
        end
        bus_stop();
        wt(4);
        check(exp_wr_q.size() == 0, "R4 all writes seen", exp_wr_q.size(), 0);
    endtask

    task automatic rd_txn(input logic [7:0] sub, input int n, input string req);
        logic [7:0] got, exp;
        bus_start();
        send_byte({DEV, 1'b0}, 1'b1, "R2");
        send_byte(sub, 1'b1, "R3");
        m_ptr = sub[6:0];
        bus_rstart();
        send_byte({DEV, 1'b1}, 1'b1, "R2");
        for (int i = 0; i < n; i++) begin
            exp = (m_ptr == CTRL) ? m_ctrl : m_mem[m_ptr];
            if (m_ctrl[0]) m_ptr = m_ptr + 7'd1;
            recv_byte(got, i < n - 1);
            check(got == exp, req, got, exp);
        end
        // R8: after the NACK the target must leave SDA alone
        recv_byte(got, 1'b0);
        check(got == 8'hFF, "R8 silent after NACK", got, 8'hFF);
        bus_stop();
    endtask

    task automatic report();
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        int cyc;
        cyc = 0;
        while (!done && cyc < 150000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            report();
        end
    end

    initial begin
        logic [7:0] dq[$];
        for (int i = 0; i < 128; i++) m_mem[i] = 8'(i) ^ 8'h5A;
        m_ctrl = 8'h01;
        m_ptr  = 7'd0;
        wt(5);
        rst_n = 1'b1;
        wt(5);

        check(sda_pull_o == 1'b0, "R1 sda released", sda_pull_o, 0);
        check(reg_wr_o == 1'b0, "R1 no strobe", reg_wr_o, 0);
        check(sda == 1'b1, "R1 bus idle high", sda, 1);

        // R11: control byte resets to 0x01
        rd_txn(8'h30, 1, "R11 ctrl reset value");

        // R3/R4: sub-address with bit 7 set lands at 0x05
        dq.delete();
        dq.push_back(8'hA1); dq.push_back(8'hB2); dq.push_back(8'hC3);
        wr_txn(DEV, 1'b1, 8'h85, dq);

        // R5/R7: read back through repeated START with increment
        rd_txn(8'h04, 5, "R5 read data");

        // R7: burst crossing the top of the pointer range
        dq.delete();
        dq.push_back(8'h11); dq.push_back(8'h22); dq.push_back(8'h33);
        wr_txn(DEV, 1'b1, 8'h7E, dq);
        rd_txn(8'h7E, 3, "R7 wrap read");

        // R2: wrong programmable bits get no acknowledge and no write
        dq.delete();
        dq.push_back(8'hEE);
        wr_txn(7'h52, 1'b0, 8'h10, dq);

        // R10: bytes without a START after a STOP are ignored
        wt(2*Q);
        m_scl = 1'b0;
        send_byte({DEV, 1'b0}, 1'b0, "R10");
        send_byte(8'h10, 1'b0, "R10");
        bus_stop();
        wt(4);
        check(exp_wr_q.size() == 0 && sda_pull_o == 1'b0, "R10 idle", sda_pull_o, 0);

        // R6: clear auto-increment, then burst to one register
        dq.delete();
        dq.push_back(8'h00);
        wr_txn(DEV, 1'b1, {1'b0, CTRL}, dq);
        dq.delete();
        dq.push_back(8'h44); dq.push_back(8'h55); dq.push_back(8'h66);
        wr_txn(DEV, 1'b1, 8'h10, dq);
        rd_txn(8'h10, 3, "R6 fixed pointer read");
        rd_txn(8'h11, 1, "R6 neighbour untouched");

        done = 1'b1;
        report();
    end

endmodule